// File: doc/BRIEF.md
# Four-Wire Serial EEPROM Slave

This block is the device side of a four-wire serial nonvolatile memory, modelled with registers in a synchronous design. A host drives a chip select, a serial clock and a serial data line, and it reads back a serial data output. An organization input picks at run time between 8-bit and 16-bit words. The block decodes each instruction from the serial stream and then acts on an internal array. It can read a word, write a word, fill the whole array with one word, erase the whole array to ones, and open or close a programming-enable latch.

Programming is self-timed. A counter in system clock cycles stands in for the device's programming delay. During that time a ready output is held low, and the block ignores any instruction that starts in that time. The serial inputs are sampled by the system clock. Serial clock edges are found from the sampled levels, so the serial clock must run much slower than the system clock.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, `ready` is 1, `sdo_oe` is 0 and the programming-enable latch is clear. A reset clears a latch that was set, so a later write has no effect.
- R2: Each frame starts after `cs` goes high. Any 0 bits before the first 1 on `sdi` are skipped, and that first 1 is the start bit. Two opcode bits follow, then the address field, then any data, all most significant bit first. Opcode 10 is read. Opcode 01 or 11 is write. Opcode 00 is an extended command, chosen by the two top bits of the address field: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: On the serial clock rise that takes in the last address bit of a read, `sdo_oe` goes to 1 and `sdo` shows a 0 dummy bit. Each of the next rises shows one data bit, most significant first. Reads work whether the latch is set or clear.
- R4: A write with the latch set stores its data word at the given address.
- R5: Write, write-all and erase-all leave the array unchanged while the latch is clear.
- R6: Only the enable command sets the latch, and only disable (or reset) clears it. The latch state carries across any number of instructions.
- R7: Erase-all makes every bit of the array 1. Write-all stores its word in every location; in x8 mode every byte gets the same data byte.
- R8: `ready` goes to 0 once the last bit of a programming instruction has been taken in. It stays 0 for max(PROG_CYCLES, 2**(ADDR_W8-1)) system clock cycles. Any instruction whose start bit arrives while `ready` is 0 is ignored.
- R9: With `org`=1, words are 16 bits and addresses are ADDR_W8-1 bits. With `org`=0, words are 8 bits and addresses are ADDR_W8 bits. The x8 byte at address 2k is the upper half of x16 word k, and the byte at 2k+1 is the lower half.
- R10: `sdo_oe` is 0 while `cs` is low. Dropping `cs` before an instruction is complete cancels it with no effect.
- R11: `sdo` changes only in response to a serial clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| org | input | 1 | Word organization: 1 for x16, 0 for x8 |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| ready | output | 1 | 1 when idle, 0 while programming runs |

## Verification
The bench uses the default ADDR_W8 of 7, which gives a 128 x 8 or 64 x 16 array, and sets PROG_CYCLES to 70. With that value the programming time is just above the 64-word walk that the bulk commands need. The bench can therefore check the exact busy length, and it has time to send a second start bit while the block is still busy. Because the array is small, the bench can read back the first and last locations after a bulk command in both organizations. It can also check how bytes map into words from both sides.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    PK_WRITE = 2'd0,
    PK_FILL  = 2'd1,
    PK_ERASE = 2'd2
  } prog_kind_t;

  typedef enum logic [2:0] {
    FS_IDLE = 3'd0,
    FS_OPC  = 3'd1,
    FS_ADDR = 3'd2,
    FS_DATA = 3'd3,
    FS_READ = 3'd4,
    FS_DONE = 3'd5
  } fe_state_t;
endpackage

// File: rtl/eep_in_sync.sv
module eep_in_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic cs_s,
  output logic sdi_s,
  output logic sclk_rise
);
  logic sclk_s, sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s   <= 1'b0;
      sdi_s  <= 1'b0;
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_s   <= cs;
      sdi_s  <= sdi;
      sclk_s <= sclk;
      sclk_d <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
endmodule

// File: rtl/eep_cmd.sv
module eep_cmd
  import eep_pkg::*;
#(
  parameter int ADDR_W8 = 7,
  localparam int WA = ADDR_W8 - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_s,
  input  logic               sdi_s,
  input  logic               sclk_rise,
  input  logic               org,
  input  logic               ready,
  input  logic [15:0]        rd_word,
  output logic [WA-1:0]      rd_addr,
  output logic               start,
  output prog_kind_t         kind,
  output logic [ADDR_W8-1:0] p_addr,
  output logic [15:0]        p_data,
  output logic               sdo,
  output logic               sdo_oe
);
  localparam int MAXF = (ADDR_W8 > 16) ? ADDR_W8 : 16;
  localparam int CW   = $clog2(MAXF + 1);

  fe_state_t          st;
  logic [CW-1:0]      cnt, out_cnt;
  logic [1:0]         opc;
  logic [ADDR_W8-1:0] addr;
  logic [15:0]        data, out_sr;
  logic               wel, rd_lo, rd_go, rd_pend;

  logic [ADDR_W8-1:0] addr_nx;
  logic [15:0]        data_nx;
  logic [1:0]         sub;
  logic [CW-1:0]      aw_last, dw_last, dw_n;

  always_comb begin
    addr_nx = {addr[ADDR_W8-2:0], sdi_s};
    data_nx = {data[14:0], sdi_s};
    sub     = org ? addr_nx[ADDR_W8-2 -: 2] : addr_nx[ADDR_W8-1 -: 2];
    aw_last = org ? CW'(ADDR_W8 - 2) : CW'(ADDR_W8 - 1);
    dw_last = org ? CW'(15) : CW'(7);
    dw_n    = org ? CW'(16) : CW'(8);
  end

  assign p_addr = addr;
  assign p_data = data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      out_cnt <= '0;
      opc     <= '0;
      addr    <= '0;
      data    <= '0;
      out_sr  <= '0;
      wel     <= 1'b0;
      start   <= 1'b0;
      kind    <= PK_WRITE;
      rd_addr <= '0;
      rd_lo   <= 1'b0;
      rd_go   <= 1'b0;
      rd_pend <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      start   <= 1'b0;
      rd_go   <= 1'b0;
      rd_pend <= rd_go;
      if (rd_pend)
        out_sr <= org ? rd_word : {(rd_lo ? rd_word[7:0] : rd_word[15:8]), 8'h00};
      if (!cs_s) begin
        st     <= FS_IDLE;
        sdo_oe <= 1'b0;
      end else if (sclk_rise) begin
        case (st)
          FS_IDLE: begin
            if (sdi_s) begin
              st  <= ready ? FS_OPC : FS_DONE;
              cnt <= '0;
            end
          end
          FS_OPC: begin
            opc <= {opc[0], sdi_s};
            if (cnt == CW'(1)) begin
              st  <= FS_ADDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_ADDR: begin
            addr <= addr_nx;
            if (cnt == aw_last) begin
              cnt <= '0;
              st  <= FS_DONE;
              if (opc == 2'b10) begin
                rd_addr <= org ? addr_nx[WA-1:0] : addr_nx[ADDR_W8-1:1];
                rd_lo   <= ~org & addr_nx[0];
                rd_go   <= 1'b1;
                sdo     <= 1'b0;
                sdo_oe  <= 1'b1;
                out_cnt <= '0;
                st      <= FS_READ;
              end else if (opc[0]) begin
                st <= FS_DATA;
              end else begin
                case (sub)
                  2'b11: wel <= 1'b1;
                  2'b00: wel <= 1'b0;
                  2'b10: begin
                    start <= wel;
                    kind  <= PK_ERASE;
                  end
                  default: st <= FS_DATA;
                endcase
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_DATA: begin
            data <= data_nx;
            if (cnt == dw_last) begin
              start <= wel;
              kind  <= (opc == 2'b00) ? PK_FILL : PK_WRITE;
              st    <= FS_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_READ: begin
            if (out_cnt == dw_n) begin
              sdo_oe <= 1'b0;
              st     <= FS_DONE;
            end else begin
              sdo     <= out_sr[15];
              out_sr  <= {out_sr[14:0], 1'b0};
              out_cnt <= out_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: output enable follows chip select going low
  a_r10_oe_off: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !sdo_oe);

  // R11: serial output moves only on a serial clock rise
  a_r11_sdo_on_edge: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && !$past(sclk_rise)) |-> $stable(sdo));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int WA = 6,
  localparam int DEPTH = 2 ** WA
) (
  input  logic          clk,
  input  logic [1:0]    we,
  input  logic [WA-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [WA-1:0] raddr,
  output logic [15:0]   rdata
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] rd_lane;
    always_ff @(posedge clk) begin
      if (we[g]) bank[waddr] <= wdata[g*8 +: 8];
      rd_lane <= bank[raddr];
    end
    assign rdata[g*8 +: 8] = rd_lane;
  end
endmodule

// File: rtl/eep_prog.sv
module eep_prog
  import eep_pkg::*;
#(
  parameter int ADDR_W8     = 7,
  parameter int PROG_CYCLES = 100,
  localparam int WA       = ADDR_W8 - 1,
  localparam int DEPTH    = 2 ** WA,
  localparam int BUSY_CYC = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH,
  localparam int CNW      = $clog2(BUSY_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  prog_kind_t         kind,
  input  logic [ADDR_W8-1:0] addr,
  input  logic [15:0]        data,
  input  logic               org,
  output logic [1:0]         we,
  output logic [WA-1:0]      waddr,
  output logic [15:0]        wdata,
  output logic               ready
);
  logic               busy, org_q;
  logic [CNW-1:0]     cnt;
  prog_kind_t         kind_q;
  logic [ADDR_W8-1:0] addr_q;
  logic [15:0]        data_q;
  logic               in_walk;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= PK_WRITE;
      addr_q <= '0;
      data_q <= '0;
      org_q  <= 1'b0;
    end else if (busy) begin
      if (cnt == CNW'(BUSY_CYC - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      kind_q <= kind;
      addr_q <= addr;
      data_q <= data;
      org_q  <= org;
    end
  end

  assign ready   = ~busy;
  assign in_walk = int'(cnt) < DEPTH;

  always_comb begin
    we    = 2'b00;
    waddr = cnt[WA-1:0];
    wdata = org_q ? data_q : {data_q[7:0], data_q[7:0]};
    case (kind_q)
      PK_WRITE: begin
        waddr = org_q ? addr_q[WA-1:0] : addr_q[ADDR_W8-1:1];
        if (busy && cnt == '0)
          we = org_q ? 2'b11 : (addr_q[0] ? 2'b01 : 2'b10);
      end
      PK_FILL: if (busy && in_walk) we = 2'b11;
      default: begin
        wdata = 16'hFFFF;
        if (busy && in_walk) we = 2'b11;
      end
    endcase
  end

  // R8: a programming start is only issued while idle
  a_r8_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> ready);

  // R8: ready drops in the cycle after a start
  a_r8_busy_follows: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready);

  // R8: ready never falls without a start
  a_r8_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(start));
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W8     = 7,
  parameter int PROG_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  input  logic org,
  output logic sdo,
  output logic sdo_oe,
  output logic ready
);
  localparam int WA = ADDR_W8 - 1;

  logic               cs_s, sdi_s, sclk_rise, start;
  prog_kind_t         kind;
  logic [ADDR_W8-1:0] p_addr;
  logic [15:0]        p_data, rd_word, wdata;
  logic [WA-1:0]      rd_addr, waddr;
  logic [1:0]         we;

  eep_in_sync u_sync (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi),
    .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise)
  );

  eep_cmd #(.ADDR_W8(ADDR_W8)) u_cmd (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise),
    .org(org), .ready(ready), .rd_word(rd_word), .rd_addr(rd_addr),
    .start(start), .kind(kind), .p_addr(p_addr), .p_data(p_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  eep_prog #(.ADDR_W8(ADDR_W8), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .addr(p_addr),
    .data(p_data), .org(org), .we(we), .waddr(waddr), .wdata(wdata),
    .ready(ready)
  );

  eep_array #(.WA(WA)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_word)
  );
endmodule

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
  localparam int PROG = 70;
  localparam int OP_RD = 0, OP_WR = 1, OP_EN = 2, OP_DS = 3, OP_ER = 4, OP_FL = 5;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
  logic sdo, sdo_oe, ready;
  int tests = 0, fails = 0, busy_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(negedge clk) if (!ready) busy_cnt++;

  serial_eeprom_slave #(.ADDR_W8(7), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi), .org(org),
    .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        o;
    logic [6:0]  a;
    logic [15:0] d;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [26] = '{
    '{3'd2, 1'b1, 7'd0,   16'h0000, 16'h0000, 4'd6},
    '{3'd4, 1'b1, 7'd0,   16'h0000, 16'h0000, 4'd7},
    '{3'd0, 1'b1, 7'd0,   16'h0000, 16'hFFFF, 4'd7},  // R7 erase-all
    '{3'd0, 1'b1, 7'd63,  16'h0000, 16'hFFFF, 4'd7},
    '{3'd1, 1'b1, 7'd5,   16'h1234, 16'h0000, 4'd4},
    '{3'd0, 1'b1, 7'd5,   16'h0000, 16'h1234, 4'd4},  // R4
    '{3'd0, 1'b0, 7'd10,  16'h0000, 16'h0012, 4'd9},  // R9 upper byte
    '{3'd0, 1'b0, 7'd11,  16'h0000, 16'h0034, 4'd9},
    '{3'd1, 1'b0, 7'd11,  16'h00AB, 16'h0000, 4'd9},
    '{3'd0, 1'b1, 7'd5,   16'h0000, 16'h12AB, 4'd9},
    '{3'd3, 1'b1, 7'd0,   16'h0000, 16'h0000, 4'd6},
    '{3'd1, 1'b1, 7'd5,   16'h5555, 16'h0000, 4'd5},
    '{3'd0, 1'b1, 7'd5,   16'h0000, 16'h12AB, 4'd5},  // R5, R3 with latch clear
    '{3'd4, 1'b1, 7'd0,   16'h0000, 16'h0000, 4'd5},
    '{3'd0, 1'b1, 7'd5,   16'h0000, 16'h12AB, 4'd6},  // R6 disable persists
    '{3'd2, 1'b1, 7'd0,   16'h0000, 16'h0000, 4'd6},
    '{3'd5, 1'b0, 7'd0,   16'h005A, 16'h0000, 4'd7},
    '{3'd0, 1'b1, 7'd0,   16'h0000, 16'h5A5A, 4'd7},  // R7 x8 fill
    '{3'd0, 1'b0, 7'd127, 16'h0000, 16'h005A, 4'd7},
    '{3'd5, 1'b1, 7'd0,   16'hC3E1, 16'h0000, 4'd7},
    '{3'd0, 1'b1, 7'd63,  16'h0000, 16'hC3E1, 4'd7},
    '{3'd0, 1'b0, 7'd1,   16'h0000, 16'h00E1, 4'd9},
    '{3'd1, 1'b1, 7'd40,  16'hBEEF, 16'h0000, 4'd6},
    '{3'd1, 1'b1, 7'd41,  16'hF00D, 16'h0000, 4'd6},
    '{3'd0, 1'b1, 7'd40,  16'h0000, 16'hBEEF, 4'd6},  // R6 enable persists
    '{3'd0, 1'b1, 7'd41,  16'h0000, 16'hF00D, 4'd6}
  };

  task automatic check(input bit ok, input string what, input int req,
                       input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic so, output logic soe, output logic pre);
    sdi  = b;
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    pre  = sdo;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    so   = sdo;
    soe  = sdo_oe;
  endtask

  task automatic send(input logic [15:0] v, input int n);
    logic so, soe, pre;
    for (int i = n - 1; i >= 0; i--) bit_x(v[i], so, soe, pre);
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs = 1'b1;
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 1000 && !ready; k++) @(negedge clk);
  endtask

  task automatic run_cmd(input int op, input logic o, input logic [6:0] a,
                         input logic [15:0] d, input bit wait_rdy, input int lead,
                         input bit wr11, output logic [15:0] rd,
                         output bit dummy_ok, output bit stable_ok);
    int aw, dw;
    logic so, soe, pre, prev;
    logic [1:0] oc, sb;
    logic [6:0] af;
    aw = o ? 6 : 7;
    dw = o ? 16 : 8;
    org = o;
    rd = '0;
    dummy_ok = 1'b1;
    stable_ok = 1'b1;
    so = 1'b0;
    soe = 1'b0;
    case (op)
      OP_RD:   oc = 2'b10;
      OP_WR:   oc = wr11 ? 2'b11 : 2'b01;
      default: oc = 2'b00;
    endcase
    case (op)
      OP_EN:   sb = 2'b11;
      OP_ER:   sb = 2'b10;
      OP_FL:   sb = 2'b01;
      default: sb = 2'b00;
    endcase
    if (op == OP_RD || op == OP_WR) af = a;
    else af = o ? {1'b0, sb, 4'b0000} : {sb, 5'b00000};
    cs_on();
    for (int i = 0; i < lead; i++) bit_x(1'b0, so, soe, pre);
    bit_x(1'b1, so, soe, pre);
    bit_x(oc[1], so, soe, pre);
    bit_x(oc[0], so, soe, pre);
    for (int i = aw - 1; i >= 0; i--) bit_x(af[i], so, soe, pre);
    if (op == OP_RD) begin
      dummy_ok = (so === 1'b0) && (soe === 1'b1);
      prev = so;
      for (int i = dw - 1; i >= 0; i--) begin
        bit_x(1'b0, so, soe, pre);
        if (pre !== prev) stable_ok = 1'b0;
        rd[i] = so;
        prev = so;
      end
    end else if (op == OP_WR || op == OP_FL) begin
      send(d, dw);
    end
    cs_off();
    if (wait_rdy) wait_ready();
  endtask

  task automatic read_chk(input logic o, input logic [6:0] a, input logic [15:0] exp,
                          input int req, input string what);
    logic [15:0] rd;
    bit dk, sk;
    run_cmd(OP_RD, o, a, 16'h0, 1'b1, 0, 1'b0, rd, dk, sk);
    check(rd === exp, what, req, rd, exp);
  endtask

  initial begin
    logic [15:0] rd;
    bit dk, sk;
    logic so, soe, pre;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready === 1'b1, "ready after reset", 1, {15'b0, ready}, 16'h1);
    check(sdo_oe === 1'b0, "sdo_oe after reset", 1, {15'b0, sdo_oe}, 16'h0);

    for (int v = 0; v < 26; v++) begin
      run_cmd(int'(VECS[v].op), VECS[v].o, VECS[v].a, VECS[v].d, 1'b1, 0, 1'b0, rd, dk, sk);
      if (int'(VECS[v].op) == OP_RD) begin
        check(rd === VECS[v].exp, "read data", int'(VECS[v].req), rd, VECS[v].exp);
        check(dk, "dummy bit 0 with output enabled (R3)", 3, 16'(dk), 16'h1);
        check(sk, "sdo steady between rises (R11)", 11, 16'(sk), 16'h1);
      end
    end

    // R2: leading zeros skipped, opcode 11 writes
    run_cmd(OP_WR, 1'b1, 7'd42, 16'h0F0F, 1'b1, 3, 1'b1, rd, dk, sk);
    run_cmd(OP_RD, 1'b1, 7'd42, 16'h0, 1'b1, 2, 1'b0, rd, dk, sk);
    check(rd === 16'h0F0F, "zeros before start bit, opcode 11", 2, rd, 16'h0F0F);

    // R8: busy length and instruction ignored while busy
    busy_cnt = 0;
    run_cmd(OP_WR, 1'b1, 7'd20, 16'h1111, 1'b0, 0, 1'b0, rd, dk, sk);
    check(ready === 1'b0, "ready low after write", 8, {15'b0, ready}, 16'h0);
    run_cmd(OP_WR, 1'b1, 7'd21, 16'h2222, 1'b0, 0, 1'b0, rd, dk, sk);
    wait_ready();
    check(busy_cnt == PROG, "busy cycles", 8, 16'(busy_cnt), 16'(PROG));
    read_chk(1'b1, 7'd21, 16'hC3E1, 8, "write during busy ignored");
    read_chk(1'b1, 7'd20, 16'h1111, 4, "first write stored");

    // R10: aborted write
    busy_cnt = 0;
    org = 1'b1;
    cs_on();
    send(16'h0005, 3);
    send(16'h0015, 6);
    send(16'h00AA, 8);
    cs_off();
    repeat (100) @(negedge clk);
    check(busy_cnt == 0, "aborted write started programming", 10, 16'(busy_cnt), 16'h0);
    read_chk(1'b1, 7'd21, 16'hC3E1, 10, "aborted write changed data");

    // R10: output enable drops with chip select mid-read
    cs_on();
    send(16'h0006, 3);
    send(16'h0028, 6);
    bit_x(1'b0, so, soe, pre);
    check(soe === 1'b1 && so === 1'b1, "first bit of BEEF mid-read", 10, {14'b0, soe, so}, 16'h3);
    cs_off();
    check(sdo_oe === 1'b0, "sdo_oe with cs low", 10, {15'b0, sdo_oe}, 16'h0);

    // R1: reset clears a set latch
    run_cmd(OP_EN, 1'b1, 7'd0, 16'h0, 1'b1, 0, 1'b0, rd, dk, sk);
    run_cmd(OP_WR, 1'b1, 7'd7, 16'h7777, 1'b1, 0, 1'b0, rd, dk, sk);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    run_cmd(OP_WR, 1'b1, 7'd7, 16'h1111, 1'b1, 0, 1'b0, rd, dk, sk);
    read_chk(1'b1, 7'd7, 16'h7777, 1, "write after reset with latch cleared");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule